// File: doc/BRIEF.md
# Coherent 64-bit Timestamp Reader

This block keeps a free-running 64-bit synchronisation timestamp counter and hands a consumer a value that is consistent across both 32-bit halves. The counter can only be looked at one half per cycle, through a registered half-select mux. It may also jump at any time, because an external load (for example a network merge) has priority over everything else. A single-cycle snapshot of both halves is therefore not available. Instead, on `rd_req` the reader fetches the upper half, then the lower half, then the upper half again. If the two upper samples differ, it repeats the lower/upper pair against the newer upper sample. It gives up after a fixed number of attempts.

The result appears on `rd_val` together with a one-cycle `rd_done` pulse. `rd_warn` flags a result that never settled. A separate set port accepts a 64-bit value and writes it into the counter as two half-word writes, low half first, high half on the following cycle. The counter advances by one per cycle while `tick_en` is high.

Top module: `ts_coherent_reader`

## Requirements
- R1: After reset, `rd_val` is zero, and `rd_done`, `rd_warn`, `rd_busy` and `set_busy` are low.
- R2: A request accepted at a clock edge in which the reader is idle samples the upper half in the cycle after that edge, the lower half in the next cycle and the upper half again in the cycle after that. If both upper samples match, `rd_done` is high exactly 4 cycles after the accepting edge with `rd_val` = {upper sample, lower sample}, and `rd_busy` is high from the cycle after the accepting edge until done.
- R3: On a mismatch, the newer upper sample becomes the reference and one lower sample and one upper sample are taken again. Each retry adds 2 cycles, so a value that settles on attempt n is delivered 2n+2 cycles after the accepting edge.
- R4: At most MAX_TRIES (default 10) attempts are made. If the last attempt also mismatches, `rd_done` rises 2*MAX_TRIES+2 cycles after acceptance with `rd_warn` = 1 and `rd_val` = {last upper sample, last lower sample}.
- R5: `rd_warn` is 0 for a result whose upper samples matched, including a match on the final allowed attempt. `rd_warn` and `rd_val` hold until the next done.
- R6: `rd_req` has no effect while `rd_busy` is high. One accepted request produces exactly one `rd_done`.
- R7: `rd_done` lasts one cycle, `rd_busy` is low in that cycle, and `rd_val`/`rd_warn` change only in a cycle where `rd_done` is high.
- R8: A `set_req` accepted while `set_busy` is low writes the low half of `set_val` at the next edge and the high half at the edge after that. `set_busy` is high for those two cycles, and a `set_req` during that time is ignored.
- R9: Counter update priority per edge: `jump_en` (load all 64 bits of `jump_val`), then a pending half write, then `tick_en` (add one, with carry from the low half into the high half).
- R10: With `tick_en`, `jump_en` and the set port idle, the counter value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance counter by one this cycle |
| jump_en | input | 1 | Load counter with `jump_val` (highest priority) |
| jump_val | input | 64 | Value loaded on a jump |
| set_req | input | 1 | Request a two-step write of `set_val` |
| set_val | input | 64 | Value for the set port |
| set_busy | output | 1 | Set port is writing its two halves |
| rd_req | input | 1 | Request a coherent read |
| rd_busy | output | 1 | Read sequence in progress |
| rd_done | output | 1 | One-cycle pulse: `rd_val` and `rd_warn` are new |
| rd_warn | output | 1 | Result did not settle within the attempt limit |
| rd_val | output | 64 | Assembled 64-bit timestamp |

## Verification
The bound checker watches, on every cycle, the rules that relate the handshake outputs to each other over time. These are the one-cycle done pulse with busy low in that cycle, result and warning changing only alongside done, busy rising only after a request, the attempt counter staying within its limit, and the set port writing low before high and never both halves at once. Whether the returned value is the right pairing of samples, and whether the latency is correct, can only be shown by the bench. It forces the counter through scripted and random per-cycle values during a read and compares the outcome with a model of the upper/lower/upper rule. The same holds for the retry counts, for a match landing on the final attempt, for write ordering seen through a following read, for jump priority over a half write, and for tick carry across the halves.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   typedef enum logic [2:0] {
      RS_IDLE,
      RS_UP_FIRST,
      RS_LO,
      RS_UP_AGAIN,
      RS_CMP
   } rd_state_t;

   typedef enum logic [1:0] {
      WS_IDLE,
      WS_LO,
      WS_HI
   } wr_state_t;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_t;

   localparam int NUM_HALVES = 2;

endpackage

// File: rtl/tsr_counter.sv
module tsr_counter
   import tsr_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic                  jump_en,
   input  logic [2*HALF_W-1:0]   jump_val,
   input  logic [NUM_HALVES-1:0] hw_en,
   input  logic [HALF_W-1:0]     hw_data,
   input  half_sel_t             sel,
   output logic [HALF_W-1:0]     half_q
);

   localparam int FULL_W = NUM_HALVES * HALF_W;

   logic [FULL_W-1:0] full_val;
   logic [FULL_W-1:0] full_inc;

   assign full_inc = full_val + {{(FULL_W-1){1'b0}}, 1'b1};

   generate
      if (HALF_W < 2) begin : g_bad_width
         $error("tsr_counter: HALF_W must be at least 2");
      end

      for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
         logic [HALF_W-1:0] q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= '0;
            end else if (jump_en) begin
               q <= jump_val[h*HALF_W +: HALF_W];
            end else if (hw_en[h]) begin
               q <= hw_data;
            end else if (tick_en) begin
               q <= full_inc[h*HALF_W +: HALF_W];
            end
         end

         assign full_val[h*HALF_W +: HALF_W] = q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         half_q <= '0;
      end else begin
         half_q <= (sel == HALF_HI) ? full_val[FULL_W-1 -: HALF_W]
                                    : full_val[HALF_W-1:0];
      end
   end

endmodule

// File: rtl/tsr_set_seq.sv
module tsr_set_seq
   import tsr_pkg::*;
#(
   parameter int HALF_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  set_req,
   input  logic [2*HALF_W-1:0]   set_val,
   output logic                  set_busy,
   output logic [NUM_HALVES-1:0] hw_en,
   output logic [HALF_W-1:0]     hw_data
);

   wr_state_t           state_q;
   logic [2*HALF_W-1:0] val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         val_q   <= '0;
      end else begin
         unique case (state_q)
            WS_IDLE: if (set_req) begin
               state_q <= WS_LO;
               val_q   <= set_val;
            end
            WS_LO:   state_q <= WS_HI;
            WS_HI:   state_q <= WS_IDLE;
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   always_comb begin
      hw_en   = '0;
      hw_data = val_q[HALF_W-1:0];
      if (state_q == WS_LO) begin
         hw_en[0] = 1'b1;
      end else if (state_q == WS_HI) begin
         hw_en[1] = 1'b1;
         hw_data  = val_q[2*HALF_W-1 -: HALF_W];
      end
   end

   assign set_busy = (state_q != WS_IDLE);

endmodule

// File: rtl/tsr_read_seq.sv
module tsr_read_seq
   import tsr_pkg::*;
#(
   parameter int HALF_W    = 32,
   parameter int MAX_TRIES = 10,
   parameter int ATT_W     = $clog2(MAX_TRIES + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rd_req,
   input  logic [HALF_W-1:0]   half_q,
   output half_sel_t           sel,
   output logic                rd_busy,
   output logic                rd_done,
   output logic                rd_warn,
   output logic [2*HALF_W-1:0] rd_val,
   output logic [ATT_W-1:0]    tries
);

   localparam logic [ATT_W-1:0] TRY_LIMIT = ATT_W'(MAX_TRIES);
   localparam logic [ATT_W-1:0] TRY_ONE   = ATT_W'(1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("tsr_read_seq: MAX_TRIES must be at least 1");
      end
   endgenerate

   rd_state_t         state_q;
   logic [HALF_W-1:0] ref_q;
   logic [HALF_W-1:0] low_q;
   logic [ATT_W-1:0]  att_q;
   logic              settled;
   logic              finish;

   assign settled = (half_q == ref_q);
   assign finish  = settled || (att_q == TRY_LIMIT);

   always_comb begin
      unique case (state_q)
         RS_UP_FIRST: sel = HALF_HI;
         RS_LO:       sel = HALF_LO;
         RS_UP_AGAIN: sel = HALF_HI;
         RS_CMP:      sel = HALF_LO;
         default:     sel = HALF_HI;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RS_IDLE;
         ref_q   <= '0;
         low_q   <= '0;
         att_q   <= '0;
         rd_done <= 1'b0;
         rd_warn <= 1'b0;
         rd_val  <= '0;
      end else begin
         rd_done <= 1'b0;
         unique case (state_q)
            RS_IDLE: if (rd_req) begin
               state_q <= RS_UP_FIRST;
               att_q   <= TRY_ONE;
            end
            RS_UP_FIRST: state_q <= RS_LO;
            RS_LO: begin
               ref_q   <= half_q;
               state_q <= RS_UP_AGAIN;
            end
            RS_UP_AGAIN: begin
               low_q   <= half_q;
               state_q <= RS_CMP;
            end
            RS_CMP: begin
               if (finish) begin
                  rd_val  <= {half_q, low_q};
                  rd_warn <= !settled;
                  rd_done <= 1'b1;
                  state_q <= RS_IDLE;
               end else begin
                  ref_q   <= half_q;
                  att_q   <= att_q + TRY_ONE;
                  state_q <= RS_UP_AGAIN;
               end
            end
            default: state_q <= RS_IDLE;
         endcase
      end
   end

   assign rd_busy = (state_q != RS_IDLE);
   assign tries   = att_q;

endmodule

// File: rtl/ts_coherent_reader.sv
module ts_coherent_reader
   import tsr_pkg::*;
#(
   parameter int HALF_W    = 32,
   parameter int MAX_TRIES = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                jump_en,
   input  logic [2*HALF_W-1:0] jump_val,
   input  logic                set_req,
   input  logic [2*HALF_W-1:0] set_val,
   output logic                set_busy,
   input  logic                rd_req,
   output logic                rd_busy,
   output logic                rd_done,
   output logic                rd_warn,
   output logic [2*HALF_W-1:0] rd_val
);

   localparam int ATT_W = $clog2(MAX_TRIES + 1);

   logic [NUM_HALVES-1:0] hw_en;
   logic [HALF_W-1:0]     hw_data;
   logic [HALF_W-1:0]     half_q;
   half_sel_t             sel;
   logic [ATT_W-1:0]      tries;

   tsr_set_seq #(.HALF_W(HALF_W)) i_setseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_req  (set_req),
      .set_val  (set_val),
      .set_busy (set_busy),
      .hw_en    (hw_en),
      .hw_data  (hw_data)
   );

   tsr_counter #(.HALF_W(HALF_W)) i_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .jump_en  (jump_en),
      .jump_val (jump_val),
      .hw_en    (hw_en),
      .hw_data  (hw_data),
      .sel      (sel),
      .half_q   (half_q)
   );

   tsr_read_seq #(.HALF_W(HALF_W), .MAX_TRIES(MAX_TRIES), .ATT_W(ATT_W)) i_rdseq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_req  (rd_req),
      .half_q  (half_q),
      .sel     (sel),
      .rd_busy (rd_busy),
      .rd_done (rd_done),
      .rd_warn (rd_warn),
      .rd_val  (rd_val),
      .tries   (tries)
   );

endmodule

// File: rtl/tsr_reader_checker.sv
module tsr_reader_checker #(
   parameter int HALF_W    = 32,
   parameter int MAX_TRIES = 10,
   parameter int ATT_W     = $clog2(MAX_TRIES + 1)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                rd_req,
   input logic                rd_busy,
   input logic                rd_done,
   input logic                rd_warn,
   input logic [2*HALF_W-1:0] rd_val,
   input logic [1:0]          hw_en,
   input logic [ATT_W-1:0]    tries
);

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !rd_busy);

   assert_val_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_val) |-> rd_done);

   assert_warn_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rd_warn) |-> rd_done);

   assert_busy_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_busy) |-> $past(rd_req));

   assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> $past(rd_busy));

   assert_try_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tries <= ATT_W'(MAX_TRIES));

   assert_low_then_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_en[0] |=> hw_en[1]);

   assert_high_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hw_en[1] |-> $past(hw_en[0]));

   assert_one_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hw_en));

endmodule

bind ts_coherent_reader tsr_reader_checker #(
   .HALF_W    (HALF_W),
   .MAX_TRIES (MAX_TRIES),
   .ATT_W     (ATT_W)
) i_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_req  (rd_req),
   .rd_busy (rd_busy),
   .rd_done (rd_done),
   .rd_warn (rd_warn),
   .rd_val  (rd_val),
   .hw_en   (hw_en),
   .tries   (tries)
);

// File: tb/test_ts_coherent_reader.sv
module test_ts_coherent_reader;

   localparam int HW = 32;
   localparam int MT = 10;
   localparam int NS = 2*MT + 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          tick_en, jump_en, set_req, rd_req;
   logic [63:0]   jump_val, set_val;
   logic          set_busy, rd_busy, rd_done, rd_warn;
   logic [63:0]   rd_val;

   int checks = 0;
   int errors = 0;
   logic [63:0] seq [NS];

   always #2 clk = ~clk;

   ts_coherent_reader #(.HALF_W(HW), .MAX_TRIES(MT)) i_ts_coherent_reader (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .jump_en(jump_en),
      .jump_val(jump_val), .set_req(set_req), .set_val(set_val),
      .set_busy(set_busy), .rd_req(rd_req), .rd_busy(rd_busy),
      .rd_done(rd_done), .rd_warn(rd_warn), .rd_val(rd_val)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Counter value held after edge k is seq[k]; attempt n compares the
   // upper half of seq[2n] with that of seq[2n-2], lower taken from seq[2n-1].
   function automatic void model(output logic [63:0] v, output bit w,
                                 output int n);
      logic [31:0] rf, up, lo;
      v = '0; w = 1'b1; n = MT;
      for (int a = 1; a <= MT; a++) begin
         rf = seq[2*a-2][63:32];
         up = seq[2*a][63:32];
         lo = seq[2*a-1][31:0];
         v  = {up, lo};
         if (up == rf) begin
            w = 1'b0; n = a;
            return;
         end
      end
   endfunction

   // Called just after a falling edge.
   task automatic do_read(input string tag, input bit load, input bit spam);
      logic [63:0] ev;
      bit          ew;
      int          en, lat, extra;
      model(ev, ew, en);
      rd_req = 1'b1;
      if (load) begin
         jump_en  = 1'b1;
         jump_val = seq[0];
      end
      lat = -1;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (k == 0) chk(rd_busy == 1'b1, {tag, " R2 busy"}, 64'(rd_busy), 64'd1);
         if (rd_done) begin
            lat = k;
            break;
         end
         rd_req = spam;
         if (load && k + 1 < NS) jump_val = seq[k+1];
         else jump_en = 1'b0;
      end
      rd_req  = 1'b0;
      jump_en = 1'b0;
      if (en == 1)            chk(lat == 2*en+2, {tag, " R2 latency"}, 64'(lat), 64'(2*en+2));
      else if (ew)            chk(lat == 2*en+2, {tag, " R4 latency"}, 64'(lat), 64'(2*en+2));
      else                    chk(lat == 2*en+2, {tag, " R3 latency"}, 64'(lat), 64'(2*en+2));
      chk(rd_val == ev, {tag, " R2/R3 value"}, rd_val, ev);
      chk(rd_warn == ew, {tag, " R5 warn"}, 64'(rd_warn), 64'(ew));
      chk(rd_busy == 1'b0, {tag, " R7 busy low at done"}, 64'(rd_busy), 64'd0);
      @(negedge clk);
      chk(rd_done == 1'b0, {tag, " R7 pulse"}, 64'(rd_done), 64'd0);
      if (spam) begin
         extra = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (rd_done) extra++;
         end
         chk(extra == 0 && !rd_busy, {tag, " R6 ignored"}, 64'(extra), 64'd0);
      end
   endtask

   task automatic fill_const(input logic [63:0] x);
      for (int k = 0; k < NS; k++) seq[k] = x;
   endtask

   task automatic jump_to(input logic [63:0] x);
      @(negedge clk);
      jump_en = 1'b1; jump_val = x;
      @(negedge clk);
      jump_en = 1'b0;
   endtask

   initial begin
      logic [63:0] cur, w, j, o;
      int r;
      r = int'($urandom(32'd20417));
      rst_n = 1'b0; tick_en = 1'b0; jump_en = 1'b0; set_req = 1'b0; rd_req = 1'b0;
      jump_val = '0; set_val = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_val == 64'd0, "R1 rd_val", rd_val, 64'd0);
      chk({rd_done, rd_warn, rd_busy, set_busy} == 4'b0, "R1 flags",
          64'({rd_done, rd_warn, rd_busy, set_busy}), 64'd0);

      // R2 frozen value
      fill_const(64'h1234_5678_9ABC_DEF0);
      do_read("frozen", 1'b1, 1'b0);

      // R3 upper rolls during first attempt
      for (int k = 0; k < NS; k++) seq[k] = 64'h5_FFFF_FFFE + 64'(k);
      @(negedge clk); do_read("rollover", 1'b1, 1'b0);

      // R4 never settles
      for (int k = 0; k < NS; k++) seq[k] = {32'(k + 1), ~32'(k)};
      @(negedge clk); do_read("unstable", 1'b1, 1'b0);

      // R5 settles exactly on last allowed attempt
      for (int k = 0; k < NS; k++) seq[k] = {32'(k < 18 ? k : 18), 32'(k * 3)};
      @(negedge clk); do_read("last_try", 1'b1, 1'b0);

      // R6 requests while busy are ignored
      fill_const(64'hCAFE_0000_0000_BEEF);
      @(negedge clk); do_read("spam", 1'b1, 1'b1);

      // R9/R10 tick carry then hold
      jump_to(64'h1_FFFF_FFFF);
      tick_en = 1'b1;
      repeat (3) @(negedge clk);
      tick_en = 1'b0;
      repeat (5) @(negedge clk);
      fill_const(64'h2_0000_0002);
      do_read("R9 tick carry", 1'b0, 1'b0);
      repeat (6) @(negedge clk);
      do_read("R10 hold", 1'b0, 1'b0);

      // R8 low half first: read started one edge after set accepted
      o = 64'hAAAA_0001_1111_0000;
      w = 64'h7777_0002_3333_4444;
      jump_to(o);
      set_req = 1'b1; set_val = w;
      @(negedge clk);
      set_req = 1'b0;
      chk(set_busy == 1'b1, "R8 set_busy", 64'(set_busy), 64'd1);
      seq[0] = {o[63:32], w[31:0]};
      for (int k = 1; k < NS; k++) seq[k] = w;
      do_read("R8 order", 1'b0, 1'b0);
      chk(set_busy == 1'b0, "R8 set_busy done", 64'(set_busy), 64'd0);

      // R9 jump beats a simultaneous half write
      w = 64'h0BAD_F00D_0000_0001;
      j = 64'h1357_2468_9999_8888;
      @(negedge clk);
      set_req = 1'b1; set_val = w;
      @(negedge clk);
      set_req = 1'b0; jump_en = 1'b1; jump_val = j;
      @(negedge clk);
      jump_en = 1'b0;
      repeat (3) @(negedge clk);
      fill_const({w[63:32], j[31:0]});
      do_read("R9 priority", 1'b0, 1'b0);

      // R8 set request during set_busy ignored
      @(negedge clk);
      set_req = 1'b1; set_val = 64'h0101_0101_0202_0202;
      @(negedge clk);
      set_val = 64'hFEFE_FEFE_EFEF_EFEF;
      @(negedge clk);
      set_req = 1'b0;
      repeat (4) @(negedge clk);
      fill_const(64'h0101_0101_0202_0202);
      do_read("R8 ignore", 1'b0, 1'b0);

      // random per-cycle counter movement
      for (int t = 0; t < 40; t++) begin
         cur = {$urandom, $urandom};
         for (int k = 0; k < NS; k++) begin
            seq[k] = cur;
            r = int'($urandom_range(0, 9));
            if (r < 3)      cur[63:32] = cur[63:32] + 32'd1;
            else if (r < 6) cur[31:0]  = cur[31:0] + 32'd1;
         end
         @(negedge clk);
         do_read("random R3", 1'b1, 1'b0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd1, 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule